// File: doc/BRIEF.md
# Programming-Mode Power Sequencer

This controller steps a socketed programmable logic device into and out of its programming mode. A start pulse turns on the supply rail. After a settle interval it raises the high edit voltage. After another interval it enables the tri-state pin drivers. After a third interval it reports ready.

A stop pulse runs the steps in reverse. The drivers go off first, then the edit voltage, then the supply. Each step again waits one settle interval. The block only sequences enable signals; the analog switching sits outside it. While the pin drivers are active, it presents a fixed set of starting pin levels: every pin low except the active-low strobe, which is high.

Top module: `prog_pwr_seq`

## Requirements
- R1: `edit_en` is never high unless `vcc_en` is high. After a start is accepted, `vcc_en` alone is high for exactly SETTLE_CYCLES cycles before `edit_en` rises.
- R2: `drv_en` is never high unless `edit_en` is high. `drv_en` rises exactly SETTLE_CYCLES cycles after `edit_en` rises.
- R3: `pin_lvl` holds bit STROBE_BIT high and every other bit low whenever `drv_en` is high.
- R4: After a stop, `drv_en` falls on the first cycle. `edit_en` stays high for SETTLE_CYCLES cycles after that, then falls.
- R5: `vcc_en` falls SETTLE_CYCLES cycles after `edit_en` falls. The block accepts a new start SETTLE_CYCLES cycles after that.
- R6: `ready` is high only while all three enables are high. It rises 3*SETTLE_CYCLES cycles after the cycle in which the start is sampled.
- R7: A start seen while the block is not idle has no effect on any output.
- R8: A stop during power-up turns off only the rails that are on, in reverse order, with one settle interval per step. A stop while the supply alone is on drops the supply at once. A stop while the supply and edit voltage are on drops the edit voltage at once, then the supply after one interval.
- R9: A synchronous reset forces every enable and `ready` low on the next cycle and returns the block to idle.
- R10: When idle, all enables are low, so the socket is unpowered for insertion. A stop seen while idle leaves every output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Power-up request pulse |
| stop_i | input | 1 | Power-down request pulse |
| vcc_en | output | 1 | Supply rail switch enable |
| edit_en | output | 1 | Edit/programming voltage switch enable |
| drv_en | output | 1 | Pin driver output enable |
| ready | output | 1 | Device is in programming mode and settled |
| pin_lvl | output | PIN_W | Levels driven on the pins while drivers are enabled |

## Verification
The bench checks the enable vector on every cycle of a full ramp and a full teardown, right up to the interval boundaries. A design whose counter is off by one would move a step one cycle early or late. A design with a wrong ordering would drop the edit voltage while the drivers are still on.

Other cases target the request handling:
- A start during the ramp, in the ready state and in the final supply-off interval. A design that does not ignore these would restart or cut the teardown short.
- A stop half-way up. A design that does not handle this would skip a step or drive the pins with the edit voltage absent.
- A reset from the ready state.

// File: rtl/prog_pwr_seq.sv
module prog_pwr_seq #(
  parameter int CLK_HZ        = 50_000_000,
  parameter int SETTLE_CYCLES = CLK_HZ / 1000,
  parameter int PIN_W         = 8,
  parameter int STROBE_BIT    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             stop_i,
  output logic             vcc_en,
  output logic             edit_en,
  output logic             drv_en,
  output logic             ready,
  output logic [PIN_W-1:0] pin_lvl
);
  localparam int CW = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYCLES - 1);
  localparam logic [PIN_W-1:0] IDLE_PINS = PIN_W'(1) << STROBE_BIT;

  typedef enum logic [2:0] {
    S_IDLE, S_UP_VCC, S_UP_EDIT, S_UP_DRV, S_READY, S_DN_DRV, S_DN_EDIT, S_DN_VCC
  } state_t;

  state_t        state, nxt;
  logic [CW-1:0] cnt;
  logic          done;

  assign done = (cnt == LAST);

  always_comb begin
    nxt = state;
    unique case (state)
      S_IDLE:    if (start_i && !stop_i) nxt = S_UP_VCC;
      S_UP_VCC:  if (stop_i) nxt = S_DN_VCC;  else if (done) nxt = S_UP_EDIT;
      S_UP_EDIT: if (stop_i) nxt = S_DN_EDIT; else if (done) nxt = S_UP_DRV;
      S_UP_DRV:  if (stop_i) nxt = S_DN_DRV;  else if (done) nxt = S_READY;
      S_READY:   if (stop_i) nxt = S_DN_DRV;
      S_DN_DRV:  if (done) nxt = S_DN_EDIT;
      S_DN_EDIT: if (done) nxt = S_DN_VCC;
      S_DN_VCC:  if (done) nxt = S_IDLE;
      default:   nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      state <= nxt;
      cnt   <= (nxt != state || done) ? '0 : cnt + 1'b1;
    end
  end

  assign vcc_en  = (state != S_IDLE) && (state != S_DN_VCC);
  assign edit_en = (state == S_UP_EDIT) || (state == S_UP_DRV) ||
                   (state == S_READY)   || (state == S_DN_DRV);
  assign drv_en  = (state == S_UP_DRV) || (state == S_READY);
  assign ready   = (state == S_READY);
  assign pin_lvl = IDLE_PINS;
endmodule

// File: rtl/prog_pwr_seq_chk.sv
module prog_pwr_seq_chk #(
  parameter int PIN_W      = 8,
  parameter int STROBE_BIT = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             vcc_en,
  input logic             edit_en,
  input logic             drv_en,
  input logic             ready,
  input logic [PIN_W-1:0] pin_lvl
);
  AST_EDIT_NEEDS_VCC: assert property (@(posedge clk) disable iff (rst)
    edit_en |-> vcc_en); // R1
  AST_DRV_NEEDS_EDIT: assert property (@(posedge clk) disable iff (rst)
    drv_en |-> edit_en); // R2
  AST_DRV_RISE_AFTER_EDIT: assert property (@(posedge clk) disable iff (rst)
    $rose(drv_en) |-> $past(edit_en)); // R2
  AST_EDIT_RISE_AFTER_VCC: assert property (@(posedge clk) disable iff (rst)
    $rose(edit_en) |-> $past(vcc_en)); // R1
  AST_STROBE_HIGH: assert property (@(posedge clk) disable iff (rst)
    drv_en |-> (pin_lvl[STROBE_BIT] && $countones(pin_lvl) == 1)); // R3
  AST_EDIT_FALL_AFTER_DRV: assert property (@(posedge clk) disable iff (rst)
    ($fell(edit_en) && !$past(rst)) |-> !$past(drv_en)); // R4
  AST_VCC_FALL_AFTER_EDIT: assert property (@(posedge clk) disable iff (rst)
    ($fell(vcc_en) && !$past(rst)) |-> !$past(edit_en)); // R5
  AST_READY_ALL_ON: assert property (@(posedge clk) disable iff (rst)
    ready |-> (vcc_en && edit_en && drv_en)); // R6
  AST_RESET_OFF: assert property (@(posedge clk)
    $past(rst) |-> !(vcc_en || edit_en || drv_en || ready)); // R9
endmodule

bind prog_pwr_seq prog_pwr_seq_chk #(.PIN_W(PIN_W), .STROBE_BIT(STROBE_BIT)) u_chk (
  .clk(clk), .rst(rst), .vcc_en(vcc_en), .edit_en(edit_en),
  .drv_en(drv_en), .ready(ready), .pin_lvl(pin_lvl)
);

// File: tb/prog_pwr_seq_bench.sv
module prog_pwr_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int S  = 4;
  localparam int PW = 8;
  localparam int SB = 3;
  localparam logic [PW-1:0] PINS_EXP = 8'b0000_1000;

  logic clk = 0, rst = 1, start_i = 0, stop_i = 0;
  logic vcc_en, edit_en, drv_en, ready;
  logic [PW-1:0] pin_lvl;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prog_pwr_seq #(.SETTLE_CYCLES(S), .PIN_W(PW), .STROBE_BIT(SB)) u_prog_pwr_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .stop_i(stop_i),
    .vcc_en(vcc_en), .edit_en(edit_en), .drv_en(drv_en), .ready(ready), .pin_lvl(pin_lvl));

  task automatic chk(input string req, input logic [3:0] exp, input int n);
    checks++;
    if ({vcc_en, edit_en, drv_en, ready} !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d: {vcc,edit,drv,ready} actual %b expected %b",
               req, n, {vcc_en, edit_en, drv_en, ready}, exp);
    end
  endtask

  function automatic logic [3:0] up_exp(input int n);
    if (n < S)        return 4'b1000;
    else if (n < 2*S) return 4'b1100;
    else if (n < 3*S) return 4'b1110;
    else              return 4'b1111;
  endfunction

  task automatic pulse_start();
    start_i = 1; @(negedge clk); start_i = 0;
  endtask

  task automatic pulse_stop();
    stop_i = 1; @(negedge clk); stop_i = 0;
  endtask

  task automatic t_reset();
    rst = 1; @(negedge clk); @(negedge clk); rst = 0; @(negedge clk);
    chk("R10", 4'b0000, 0);
    stop_i = 1; @(negedge clk); stop_i = 0; @(negedge clk);
    chk("R10", 4'b0000, 1);
  endtask

  task automatic t_ramp();
    pulse_start();
    for (int n = 0; n <= 3*S + 2; n++) begin
      chk(n < 3*S ? "R1/R2" : "R6", up_exp(n), n);
      if (drv_en) begin
        checks++;
        if (pin_lvl !== PINS_EXP) begin
          errors++;
          $display("FAIL R3: pin_lvl actual %b expected %b", pin_lvl, PINS_EXP);
        end
      end
      start_i = (n == 2);
      @(negedge clk);
    end
    start_i = 0;
  endtask

  task automatic t_start_ignored();
    for (int n = 0; n < 2*S; n++) begin
      start_i = (n == 0);
      @(negedge clk);
      start_i = 0;
      chk("R7", 4'b1111, n);
    end
  endtask

  task automatic t_teardown();
    pulse_stop();
    for (int n = 0; n <= 3*S + 3; n++) begin
      if (n < S)        chk("R4", 4'b1100, n);
      else if (n < 2*S) chk("R5", 4'b1000, n);
      else              chk(n < 3*S ? "R5" : "R7", 4'b0000, n);
      start_i = (n == 2*S + 1);
      @(negedge clk);
    end
    start_i = 0;
    pulse_start();
    chk("R5", 4'b1000, 0);
  endtask

  task automatic t_stop_mid();
    for (int n = 1; n <= S; n++) @(negedge clk);
    chk("R8", 4'b1100, 0);
    pulse_stop();
    for (int n = 0; n <= S + 1; n++) begin
      chk("R8", n < S ? 4'b1000 : 4'b0000, n);
      @(negedge clk);
    end
    pulse_start();
    pulse_stop();
    chk("R8", 4'b0000, 0);
  endtask

  task automatic t_reset_mid();
    pulse_start();
    for (int n = 1; n <= 3*S; n++) @(negedge clk);
    chk("R6", 4'b1111, 0);
    rst = 1; @(negedge clk); rst = 0;
    chk("R9", 4'b0000, 0);
    @(negedge clk); @(negedge clk);
    chk("R9", 4'b0000, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_ramp();
    t_start_ignored();
    t_teardown();
    t_stop_mid();
    t_reset_mid();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule